// File: doc/BRIEF.md
# Byte ALU with Status Flags and Branch-Condition Decode

This block is the arithmetic and logic datapath of a small 8-bit processor core. Every cycle in which the enable input is high, it takes two operands and a 4-bit operation code, then produces a registered result and updates a registered eight-bit status word. The operations are add, add with carry, subtract, subtract with borrow, compare, the three bitwise logic functions, four rotates, three shifts, and a direct load of the status word.

A combinational evaluator reads the stored status word and a 4-bit condition selector and produces a branch-taken bit. A sequencer can therefore test the outcome of the last operation in the cycle after that operation was issued. The status word carries carry, zero, sign and overflow for branching. It also carries two helper bits for later decimal correction, and two user bits that only the load operation can change.

Top module: `alu8_flagged`

## Requirements
- R1: A synchronous reset clears `result` and `flags` to 0x00 at the next rising clock edge.
- R2: The status word bits, from bit 7 down to bit 0, are C, Z, S, V, D, H, F2, F1. After every arithmetic, logic, rotate or shift operation, Z is 1 exactly when the 8-bit result is zero and S equals bit 7 of that result.
- R3: Add (code 0x0) and add-with-carry (0x1, which also adds the stored C) write a+b(+C). C is the carry out of bit 7 and H is the carry out of bit 3. V is 1 when both operands have the same sign and the result sign differs. D is cleared.
- R4: Subtract (0x2) and subtract-with-borrow (0x3, which also subtracts the stored C) write a-b(-C). C is 1 when b plus the borrow in exceeds a. H is 1 when a borrow is taken from bit 4. V is 1 when the operand signs differ and the result sign equals the sign of b. D is set.
- R5: Compare (0x4) updates C, Z, S, V, D and H exactly as subtract does, and leaves `result` unchanged.
- R6: AND (0x5), OR (0x6) and XOR (0x7) write the bitwise result and clear V. C, D and H keep their values.
- R7: Rotate left (0x8), rotate left through C (0x9), rotate right (0xA), rotate right through C (0xB), shift left (0xC, zero fill), arithmetic shift right (0xD, sign kept) and logical shift right (0xE, zero fill) move the bit that leaves the byte into C. V is 1 when bit 7 of the result differs from bit 7 of a. D and H keep their values.
- R8: F1 and F2 change only on load-status (0xF), which copies `opnd_a` into the whole status word and leaves `result` unchanged.
- R9: With `op_en` low, `result` and `flags` hold their values whatever the other inputs do.
- R10: `cc_taken` is a combinational function of `flags` and `cc_sel`. The codes are: 0 never; 1 S^V; 2 Z|(S^V); 3 C|Z; 4 V; 5 S; 6 Z; 7 C; 8 always. Codes 9 to 15 are the inverses of codes 1 to 7 in the same order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_en | input | 1 | Perform the operation this cycle |
| op_code | input | 4 | Operation selector |
| opnd_a | input | DATA_W | Destination / first operand |
| opnd_b | input | DATA_W | Source / second operand |
| cc_sel | input | 4 | Condition code to evaluate |
| result | output | DATA_W | Registered result |
| flags | output | 8 | Registered status word |
| cc_taken | output | 1 | Condition true for the current status word |

## Verification
The bench builds the block with its defaults: an 8-bit datapath and a 4-bit half-carry nibble. At that width the sign boundary 0x7F/0x80, the wrap at 0xFF and the nibble boundary 0x0F/0x10 can all be reached with directed operands. Every flag rule can then be probed at both of its edges. Random operand streams mixed with load-status operations set arbitrary status words. Sweeping all sixteen condition codes against those words covers every entry of the branch table.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [3:0] {
    OP_ADD = 4'h0,
    OP_ADC = 4'h1,
    OP_SUB = 4'h2,
    OP_SBC = 4'h3,
    OP_CMP = 4'h4,
    OP_AND = 4'h5,
    OP_OR  = 4'h6,
    OP_XOR = 4'h7,
    OP_RL  = 4'h8,
    OP_RLC = 4'h9,
    OP_RR  = 4'hA,
    OP_RRC = 4'hB,
    OP_SLA = 4'hC,
    OP_SRA = 4'hD,
    OP_SRL = 4'hE,
    OP_LDF = 4'hF
  } alu_op_e;

  // status word, msb first: C Z S V D H F2 F1
  typedef struct packed {
    logic c;
    logic z;
    logic s;
    logic v;
    logic d;
    logic h;
    logic f2;
    logic f1;
  } stat_t;

  localparam int STAT_W = 8;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int DATA_W = 8,
  parameter int HALF_W = 4
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  input  logic              do_sub,
  output logic [DATA_W-1:0] res,
  output logic              cout,
  output logic              hout,
  output logic              vout
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W:0] wide_sum;
  logic [HALF_W:0] nib_sum;
  logic [DATA_W:0] b_plus;
  logic [HALF_W:0] nb_plus;

  always_comb begin
    wide_sum = '0;
    nib_sum  = '0;
    b_plus   = {1'b0, b} + {{DATA_W{1'b0}}, cin};
    nb_plus  = {1'b0, b[HALF_W-1:0]} + {{HALF_W{1'b0}}, cin};
    if (!do_sub) begin
      wide_sum = {1'b0, a} + b_plus;
      nib_sum  = {1'b0, a[HALF_W-1:0]} + nb_plus;
      res      = wide_sum[DATA_W-1:0];
      cout     = wide_sum[DATA_W];
      hout     = nib_sum[HALF_W];
      vout     = (a[MSB] == b[MSB]) && (res[MSB] != a[MSB]);
    end else begin
      res      = a - b_plus[DATA_W-1:0];
      cout     = b_plus > {1'b0, a};
      hout     = nb_plus > {1'b0, a[HALF_W-1:0]};
      vout     = (a[MSB] != b[MSB]) && (res[MSB] == b[MSB]);
    end
  end
endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  input  logic [3:0]        sel,
  output logic [DATA_W-1:0] res,
  output logic              cout
);
  localparam int MSB = DATA_W - 1;

  always_comb begin
    res  = '0;
    cout = cin;
    case (sel)
      4'h5: res = a & b;
      4'h6: res = a | b;
      4'h7: res = a ^ b;
      4'h8: begin res = {a[MSB-1:0], a[MSB]}; cout = a[MSB]; end
      4'h9: begin res = {a[MSB-1:0], cin};    cout = a[MSB]; end
      4'hA: begin res = {a[0], a[MSB:1]};     cout = a[0];   end
      4'hB: begin res = {cin, a[MSB:1]};      cout = a[0];   end
      4'hC: begin res = {a[MSB-1:0], 1'b0};   cout = a[MSB]; end
      4'hD: begin res = {a[MSB], a[MSB:1]};   cout = a[0];   end
      4'hE: begin res = {1'b0, a[MSB:1]};     cout = a[0];   end
      default: begin res = '0; cout = cin; end
    endcase
  end
endmodule

// File: rtl/alu8_ccdec.sv
module alu8_ccdec
  import alu8_pkg::*;
#(
  parameter int CC_W = 4
) (
  input  stat_t           st,
  input  logic [CC_W-1:0] code,
  output logic            taken
);
  logic base;
  logic lt;

  always_comb begin
    lt = st.s ^ st.v;
    case (code[2:0])
      3'd0: base = 1'b0;
      3'd1: base = lt;
      3'd2: base = st.z | lt;
      3'd3: base = st.c | st.z;
      3'd4: base = st.v;
      3'd5: base = st.s;
      3'd6: base = st.z;
      default: base = st.c;
    endcase
    taken = code[CC_W-1] ? ~base : base;
  end
endmodule

// File: rtl/alu8_flagged.sv
module alu8_flagged
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int HALF_W = 4,
  parameter int OP_W   = 4,
  parameter int CC_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_en,
  input  logic [OP_W-1:0]   op_code,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [CC_W-1:0]   cc_sel,
  output logic [DATA_W-1:0] result,
  output logic [7:0]        flags,
  output logic              cc_taken
);
  localparam int MSB = DATA_W - 1;

  stat_t             st_q, st_d;
  logic [DATA_W-1:0] res_q, res_d;

  alu_op_e           op;
  logic              is_sub, use_cin;
  logic [DATA_W-1:0] as_res, bo_res;
  logic              as_c, as_h, as_v, bo_c;

  assign op      = alu_op_e'(op_code);
  assign is_sub  = (op == OP_SUB) || (op == OP_SBC) || (op == OP_CMP);
  assign use_cin = (op == OP_ADC) || (op == OP_SBC);

  alu8_addsub #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_addsub (
    .a      (opnd_a),
    .b      (opnd_b),
    .cin    (use_cin & st_q.c),
    .do_sub (is_sub),
    .res    (as_res),
    .cout   (as_c),
    .hout   (as_h),
    .vout   (as_v)
  );

  alu8_bitops #(.DATA_W(DATA_W)) u_bitops (
    .a    (opnd_a),
    .b    (opnd_b),
    .cin  (st_q.c),
    .sel  (op_code),
    .res  (bo_res),
    .cout (bo_c)
  );

  always_comb begin
    st_d  = st_q;
    res_d = res_q;
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC: begin
        res_d  = as_res;
        st_d.c = as_c;
        st_d.h = as_h;
        st_d.v = as_v;
        st_d.d = is_sub;
        st_d.z = (as_res == '0);
        st_d.s = as_res[MSB];
      end
      OP_CMP: begin
        st_d.c = as_c;
        st_d.h = as_h;
        st_d.v = as_v;
        st_d.d = 1'b1;
        st_d.z = (as_res == '0);
        st_d.s = as_res[MSB];
      end
      OP_AND, OP_OR, OP_XOR: begin
        res_d  = bo_res;
        st_d.v = 1'b0;
        st_d.z = (bo_res == '0);
        st_d.s = bo_res[MSB];
      end
      OP_LDF: begin
        st_d = stat_t'(opnd_a[7:0]);
      end
      default: begin
        res_d  = bo_res;
        st_d.c = bo_c;
        st_d.v = bo_res[MSB] ^ opnd_a[MSB];
        st_d.z = (bo_res == '0);
        st_d.s = bo_res[MSB];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= '0;
      res_q <= '0;
    end else if (op_en) begin
      st_q  <= st_d;
      res_q <= res_d;
    end
  end

  alu8_ccdec #(.CC_W(CC_W)) u_ccdec (
    .st    (st_q),
    .code  (cc_sel),
    .taken (cc_taken)
  );

  assign result = res_q;
  assign flags  = st_q;
endmodule

// File: rtl/alu8_flagged_chk.sv
module alu8_flagged_chk #(
  parameter int DATA_W = 8,
  parameter int OP_W   = 4,
  parameter int CC_W   = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              op_en,
  input logic [OP_W-1:0]   op_code,
  input logic [DATA_W-1:0] opnd_a,
  input logic [DATA_W-1:0] opnd_b,
  input logic [CC_W-1:0]   cc_sel,
  input logic [DATA_W-1:0] result,
  input logic [7:0]        flags,
  input logic              cc_taken
);
  logic is_arith_add, is_arith_sub, is_logic, is_ldf, is_cmp;
  assign is_arith_add = (op_code == 4'h0) || (op_code == 4'h1);
  assign is_arith_sub = (op_code == 4'h2) || (op_code == 4'h3) || (op_code == 4'h4);
  assign is_logic     = (op_code == 4'h5) || (op_code == 4'h6) || (op_code == 4'h7);
  assign is_ldf       = (op_code == 4'hF);
  assign is_cmp       = (op_code == 4'h4);

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (result == '0) && (flags == 8'h00)); // R1

  AST_ZERO_TRACKS_RESULT: assert property (@(posedge clk) disable iff (rst)
    (op_en && !is_ldf && !is_cmp) |=> (flags[6] == (result == '0)) && (flags[5] == result[DATA_W-1])); // R2

  AST_ADD_CLEARS_D: assert property (@(posedge clk) disable iff (rst)
    (op_en && is_arith_add) |=> !flags[3]); // R3

  AST_SUB_SETS_D: assert property (@(posedge clk) disable iff (rst)
    (op_en && is_arith_sub) |=> flags[3]); // R4

  AST_CMP_KEEPS_RESULT: assert property (@(posedge clk) disable iff (rst)
    (op_en && is_cmp) |=> $stable(result)); // R5

  AST_LOGIC_CLEARS_V: assert property (@(posedge clk) disable iff (rst)
    (op_en && is_logic) |=> !flags[4] && $stable(flags[3:2]) && $stable(flags[7])); // R6

  AST_USER_BITS_KEPT: assert property (@(posedge clk) disable iff (rst)
    (op_en && !is_ldf) |=> $stable(flags[1:0])); // R8

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !op_en |=> $stable(flags) && $stable(result)); // R9

  AST_CC_FIXED_CODES: assert property (@(posedge clk) disable iff (rst)
    ((cc_sel == 4'h8) |-> cc_taken) and ((cc_sel == 4'h0) |-> !cc_taken)); // R10
endmodule

bind alu8_flagged alu8_flagged_chk #(.DATA_W(DATA_W), .OP_W(OP_W), .CC_W(CC_W)) u_chk (
  .clk(clk), .rst(rst), .op_en(op_en), .op_code(op_code), .opnd_a(opnd_a),
  .opnd_b(opnd_b), .cc_sel(cc_sel), .result(result), .flags(flags), .cc_taken(cc_taken)
);

// File: tb/test_alu8_flagged.sv
module test_alu8_flagged;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          op_en = 1'b0;
  logic [3:0]    op_code = '0;
  logic [DW-1:0] opnd_a = '0, opnd_b = '0;
  logic [3:0]    cc_sel = '0;
  logic [DW-1:0] result;
  logic [7:0]    flags;
  logic          cc_taken;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  logic [7:0] m_res = 8'h00;
  logic [7:0] m_fl  = 8'h00;

  logic [7:0] q_res[$];
  logic [7:0] q_fl[$];
  logic       q_tk[$];
  logic [3:0] q_cc[$];
  int         q_op[$];

  always #2 clk = ~clk;

  alu8_flagged i_alu8_flagged (
    .clk(clk), .rst(rst), .op_en(op_en), .op_code(op_code), .opnd_a(opnd_a),
    .opnd_b(opnd_b), .cc_sel(cc_sel), .result(result), .flags(flags), .cc_taken(cc_taken)
  );

  function automatic string tag_of(int op);
    if (op < 0) return "R9 idle";
    if (op <= 1) return "R3 add";
    if (op <= 3) return "R4 sub";
    if (op == 4) return "R5 cmp";
    if (op <= 7) return "R6 logic";
    if (op <= 14) return "R7 rot/shift";
    return "R8 load-status";
  endfunction

  // condition table, written from R10
  function automatic logic cc_ref(logic [7:0] f, logic [3:0] c);
    logic fc, fz, fs, fv;
    fc = f[7]; fz = f[6]; fs = f[5]; fv = f[4];
    case (c)
      4'h0: return 1'b0;
      4'h1: return fs != fv;
      4'h2: return fz || (fs != fv);
      4'h3: return fc || fz;
      4'h4: return fv;
      4'h5: return fs;
      4'h6: return fz;
      4'h7: return fc;
      4'h8: return 1'b1;
      4'h9: return fs == fv;
      4'hA: return !fz && (fs == fv);
      4'hB: return !fc && !fz;
      4'hC: return !fv;
      4'hD: return !fs;
      4'hE: return !fz;
      default: return !fc;
    endcase
  endfunction

  task automatic model(int op, logic [7:0] a, logic [7:0] b);
    int ia, ib, ci, t;
    logic [7:0] r;
    ia = a; ib = b; ci = m_fl[7];
    r = m_res;
    case (op)
      0, 1: begin
        t = ia + ib + ((op == 1) ? ci : 0);
        r = t[7:0];
        m_fl[7] = t > 255;
        m_fl[2] = ((ia % 16) + (ib % 16) + ((op == 1) ? ci : 0)) > 15;
        m_fl[4] = (a[7] == b[7]) && (r[7] != a[7]);
        m_fl[3] = 1'b0;
      end
      2, 3, 4: begin
        t = ia - ib - ((op == 3) ? ci : 0);
        m_fl[7] = t < 0;
        m_fl[2] = ((ia % 16) - (ib % 16) - ((op == 3) ? ci : 0)) < 0;
        t = t + 256;
        m_fl[4] = (a[7] != b[7]) && (t[7] == b[7]);
        m_fl[3] = 1'b1;
        if (op != 4) r = t[7:0];
        else begin
          m_fl[6] = t[7:0] == 0; m_fl[5] = t[7];
        end
      end
      5: begin r = a & b; m_fl[4] = 0; end
      6: begin r = a | b; m_fl[4] = 0; end
      7: begin r = a ^ b; m_fl[4] = 0; end
      15: m_fl = a;
      default: begin
        case (op)
          8:  r = (a << 1) | (a >> 7);
          9:  r = (a << 1) | 8'(ci);
          10: r = (a >> 1) | (a << 7);
          11: r = (a >> 1) | (ci ? 8'h80 : 8'h00);
          12: r = a << 1;
          13: r = (a >> 1) | (a & 8'h80);
          default: r = a >> 1;
        endcase
        m_fl[7] = (op == 8 || op == 9 || op == 12) ? a[7] : a[0];
        m_fl[4] = r[7] != a[7];
      end
    endcase
    if (op != 4 && op != 15) begin
      m_fl[6] = (r == 0);
      m_fl[5] = r[7];
    end
    m_res = r;
  endtask

  // driver: op < 0 means op_en low with junk on the other inputs
  task automatic drive(int op, logic [7:0] a, logic [7:0] b, logic [3:0] cc);
    @(negedge clk);
    op_en   = (op >= 0);
    op_code = (op >= 0) ? 4'(op) : 4'(a);
    opnd_a  = a;
    opnd_b  = b;
    cc_sel  = cc;
    if (op >= 0) model(op, a, b);
    q_res.push_back(m_res);
    q_fl.push_back(m_fl);
    q_cc.push_back(cc);
    q_tk.push_back(cc_ref(m_fl, cc));
    q_op.push_back(op);
  endtask

  // monitor: one item per rising edge, sampled 1 ns later
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q_res.size() > 0) begin
        logic [7:0] er, ef;
        logic [3:0] ec;
        logic et;
        int eo;
        er = q_res.pop_front(); ef = q_fl.pop_front();
        ec = q_cc.pop_front();  et = q_tk.pop_front(); eo = q_op.pop_front();
        n_cmp++;
        if (result !== er) begin
          n_bad++;
          $display("FAIL %s result: actual %h expected %h", tag_of(eo), result, er);
        end
        n_cmp++;
        if (flags !== ef) begin
          n_bad++;
          $display("FAIL %s flags (R2 layout/Z/S, R8 user bits): actual %b expected %b",
                   tag_of(eo), flags, ef);
        end
        n_cmp++;
        if (cc_taken !== et) begin
          n_bad++;
          $display("FAIL R10 cc %h on flags %b: actual %b expected %b", ec, flags, cc_taken, et);
        end
      end
    end
  end

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    n_cmp++;
    if (result !== 8'h00 || flags !== 8'h00) begin
      n_bad++;
      $display("FAIL R1 reset: actual %h/%h expected 00/00", result, flags);
    end
    // R3 corners: signed overflow, carry out, half carry
    drive(0, 8'h7F, 8'h01, 4'h4);
    drive(0, 8'hFF, 8'h01, 4'h7);
    drive(1, 8'h10, 8'h20, 4'h3);
    drive(0, 8'h80, 8'h80, 4'h1);
    drive(1, 8'h0F, 8'h00, 4'h6);
    // R4 corners: borrow, nibble borrow, sub overflow
    drive(2, 8'h10, 8'h01, 4'h7);
    drive(2, 8'h00, 8'h01, 4'hF);
    drive(2, 8'h80, 8'h01, 4'h4);
    drive(3, 8'h05, 8'h05, 4'h6);
    drive(2, 8'h7F, 8'hFF, 4'hC);
    // R5 compare keeps result
    drive(4, 8'h33, 8'h33, 4'h6);
    drive(4, 8'h01, 8'h02, 4'h7);
    // R6 logic after an overflow
    drive(0, 8'h40, 8'h40, 4'h4);
    drive(5, 8'hF0, 8'h0F, 4'h6);
    drive(6, 8'h80, 8'h01, 4'h5);
    drive(7, 8'hAA, 8'hAA, 4'hE);
    // R7 rotates and shifts, sign change, through carry
    for (int k = 8; k <= 14; k++) begin
      drive(k, 8'h81, 8'h00, 4'h4);
      drive(k, 8'h40, 8'h00, 4'h7);
    end
    // R8 user bits, R9 idle with hostile inputs
    drive(15, 8'h03, 8'h00, 4'h0);
    drive(0, 8'h01, 8'h02, 4'h8);
    drive(-1, 8'hFF, 8'hFF, 4'h8);
    drive(-1, 8'h04, 8'h00, 4'h2);
    // R10 full table on many status words
    for (int w = 0; w < 256; w += 17) begin
      drive(15, 8'(w), 8'h00, 4'h0);
      for (int c = 0; c < 16; c++) drive(-1, 8'h0F, 8'(c), 4'(c));
    end
    // random mix
    for (int i = 0; i < 600; i++) begin
      int op;
      op = $urandom_range(0, 15);
      if ($urandom_range(0, 7) == 0) op = -1;
      drive(op, 8'($urandom), 8'($urandom), 4'($urandom));
    end
    drive(-1, 8'h00, 8'h00, 4'h8);
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    done = 1;
    $finish;
  end
endmodule